// File: doc/BRIEF.md
# 8-bit ALU with flags

This block is the arithmetic and logic unit of a small accumulator-based core. It has no clock and no state. It takes two 8-bit operands, a 4-bit operation code and the core's current carry and auxiliary carry. From these it forms an 8-bit result and new values for the carry, auxiliary carry, zero and overflow flags. For each flag it also drives an update enable, which tells the surrounding flag register whether that flag should be written this instruction.

One nibble-split adder serves add, add-with-carry, subtract, subtract-with-borrow, increment and decrement. Subtraction follows the inverted-borrow convention: a carry of 1 after a subtract means that no borrow occurred. A separate path handles decimal adjust, the bitwise operations and the four rotates. When a flag's update enable is low, that flag's value output is forced to 0, so the consumer never sees a stale value.

Top module: `alu8_core`

## Requirements
- R1: op_i encodes ADD=0, ADC=1, SUB=2, SBC=3, DAA=4, AND=5, OR=6, XOR=7, CPL=8, RL=9, RR=10, RLC=11, RRC=12, INC=13, DEC=14. Code 15 returns a_i unchanged and updates no flag.
- R2: ADD returns (a_i + b_i) mod 256 and ignores c_i. ADC returns (a_i + b_i + c_i) mod 256. For both, c_o is the carry out of bit 7.
- R3: SUB computes a_i + ~b_i + 1 and SBC computes a_i + ~b_i + c_i. For both, c_o is 1 when no borrow occurs, which for SUB means a_i >= b_i.
- R4: For ADD, ADC, SUB and SBC, ac_o is the carry out of bit 3 of the same sum. For subtracts this means 1 when the low nibble does not borrow.
- R5: For ADD, ADC, SUB and SBC, ov_o is 1 when the carry into bit 7 differs from the carry out of bit 7.
- R6: z_o is 1 exactly when res_o is 0, for the operations ADD, ADC, SUB, SBC, AND, OR, XOR, CPL, INC and DEC.
- R7: DAA adds 06h when a_i[3:0] > 9 or ac_i is 1. It adds 60h when a_i[7:4] > 9 or c_i is 1. c_o is 1 if that addition carries out of bit 7; otherwise c_o equals c_i. DAA updates only the carry flag.
- R8: AND, OR and XOR combine a_i and b_i bitwise. CPL returns ~a_i and ignores b_i.
- R9: RL returns {a[6:0],a[7]} and RR returns {a[0],a[7:1]}; neither updates any flag. RLC returns {a[6:0],c_i} and loads c_o from a[7]. RRC returns {c_i,a[7:1]} and loads c_o from a[0]. RLC and RRC update only the carry flag.
- R10: INC returns (a_i+1) mod 256 and DEC returns (a_i-1) mod 256. Both update only the zero flag.
- R11: Update enables, given as {c,ac,z,ov}: 1111 for ADD, ADC, SUB and SBC; 1000 for DAA, RLC and RRC; 0010 for AND, OR, XOR, CPL, INC and DEC; 0000 otherwise. Any flag output whose enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| op_i | input | 4 | Operation code |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary carry flag |
| res_o | output | 8 | Result |
| c_o | output | 1 | Next carry value |
| ac_o | output | 1 | Next auxiliary carry value |
| z_o | output | 1 | Next zero value |
| ov_o | output | 1 | Next overflow value |
| upd_c_o | output | 1 | Carry update enable |
| upd_ac_o | output | 1 | Auxiliary carry update enable |
| upd_z_o | output | 1 | Zero update enable |
| upd_ov_o | output | 1 | Overflow update enable |

## Verification
The flag paths that can fire together in one operation are the focus: carry with zero, and carry with overflow, both produced by the shared adder. FF+01 makes carry and zero appear together, and 80h-01 makes a no-borrow carry appear alongside signed overflow. Each vector compares the whole flag vector and the enable vector at once, so a flag raised in the wrong operation or masked the wrong way is caught. Sweeps of ADD and SUB over many operand pairs then judge all four flags together against values the bench derives from plain integer arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_DAA = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_CPL = 4'd8,  OP_RL  = 4'd9,  OP_RR  = 4'd10, OP_RLC = 4'd11,
    OP_RRC = 4'd12, OP_INC = 4'd13, OP_DEC = 4'd14, OP_NOP = 4'd15
  } op_e;

  typedef struct packed {
    logic c;
    logic ac;
    logic z;
    logic ov;
  } flags_t;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int DW = alu8_pkg::DW,
  parameter int NW = alu8_pkg::NW
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          c_half_o,
  output logic          c_msb_in_o,
  output logic          c_out_o
);
  localparam int MW = DW - 1 - NW;

  logic [NW:0] lo;
  logic [MW:0] mid;
  logic [1:0]  top;

  // split so the nibble and bit-7 carries are visible
  assign lo  = {1'b0, x_i[NW-1:0]} + {1'b0, y_i[NW-1:0]} + {{NW{1'b0}}, cin_i};
  assign mid = {1'b0, x_i[DW-2:NW]} + {1'b0, y_i[DW-2:NW]} + {{MW{1'b0}}, lo[NW]};
  assign top = {1'b0, x_i[DW-1]} + {1'b0, y_i[DW-1]} + {1'b0, mid[MW]};

  assign sum_o      = {top[0], mid[MW-1:0], lo[NW-1:0]};
  assign c_half_o   = lo[NW];
  assign c_msb_in_o = mid[MW];
  assign c_out_o    = top[1];
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int DW = alu8_pkg::DW,
  parameter int NW = alu8_pkg::NW
) (
  input  logic [DW-1:0] a_i,
  input  logic          c_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  localparam logic [NW-1:0] DIGIT_MAX = NW'(9);
  localparam logic [NW-1:0] DIGIT_ADJ = NW'(6);

  logic          lo_fix, hi_fix;
  logic [DW-1:0] adj;
  logic [DW:0]   sum;

  assign lo_fix = (a_i[NW-1:0] > DIGIT_MAX) | ac_i;
  assign hi_fix = (a_i[DW-1:NW] > DIGIT_MAX) | c_i;
  assign adj    = {hi_fix ? DIGIT_ADJ : '0, lo_fix ? DIGIT_ADJ : '0};
  assign sum    = {1'b0, a_i} + {1'b0, adj};
  assign res_o  = sum[DW-1:0];
  assign c_o    = sum[DW] | c_i;  // carry kept if no new carry
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = alu8_pkg::DW
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_CPL:  res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_rot.sv
module alu8_rot
  import alu8_pkg::*;
#(
  parameter int DW = alu8_pkg::DW
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  always_comb begin
    res_o = a_i;
    c_o   = 1'b0;
    unique case (op_i)
      OP_RL:  res_o = {a_i[DW-2:0], a_i[DW-1]};
      OP_RR:  res_o = {a_i[0], a_i[DW-1:1]};
      OP_RLC: begin res_o = {a_i[DW-2:0], c_i}; c_o = a_i[DW-1]; end
      OP_RRC: begin res_o = {c_i, a_i[DW-1:1]}; c_o = a_i[0];    end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW  = alu8_pkg::DW,
  parameter int OPW = alu8_pkg::OPW
) (
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [OPW-1:0] op_i,
  input  logic           c_i,
  input  logic           ac_i,
  output logic [DW-1:0]  res_o,
  output logic           c_o,
  output logic           ac_o,
  output logic           z_o,
  output logic           ov_o,
  output logic           upd_c_o,
  output logic           upd_ac_o,
  output logic           upd_z_o,
  output logic           upd_ov_o
);
  op_e op;
  assign op = op_e'(op_i);

  // shared adder: add, sub (A + ~B + cin), inc, dec
  logic [DW-1:0] add_y, add_sum;
  logic          add_cin, add_c_half, add_c_msb_in, add_c_out;

  always_comb begin
    add_y   = b_i;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC: add_cin = c_i;
      OP_SUB: begin add_y = ~b_i; add_cin = 1'b1; end
      OP_SBC: begin add_y = ~b_i; add_cin = c_i;  end
      OP_INC: begin add_y = '0;   add_cin = 1'b1; end
      OP_DEC: add_y = '1;
      default: ;
    endcase
  end

  alu8_adder #(.DW(DW)) u_adder (
    .x_i        (a_i),
    .y_i        (add_y),
    .cin_i      (add_cin),
    .sum_o      (add_sum),
    .c_half_o   (add_c_half),
    .c_msb_in_o (add_c_msb_in),
    .c_out_o    (add_c_out)
  );

  logic [DW-1:0] daa_res, log_res, rot_res;
  logic          daa_c, rot_c;

  alu8_daa #(.DW(DW)) u_daa (
    .a_i   (a_i),
    .c_i   (c_i),
    .ac_i  (ac_i),
    .res_o (daa_res),
    .c_o   (daa_c)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (log_res)
  );

  alu8_rot #(.DW(DW)) u_rot (
    .op_i  (op),
    .a_i   (a_i),
    .c_i   (c_i),
    .res_o (rot_res),
    .c_o   (rot_c)
  );

  flags_t upd, raw;

  always_comb begin
    res_o = a_i;
    upd   = '0;
    raw   = '0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_o  = add_sum;
        upd    = '{c: 1'b1, ac: 1'b1, z: 1'b1, ov: 1'b1};
        raw.c  = add_c_out;
        raw.ac = add_c_half;
        raw.ov = add_c_msb_in ^ add_c_out;
      end
      OP_INC, OP_DEC: begin
        res_o = add_sum;
        upd.z = 1'b1;
      end
      OP_DAA: begin
        res_o = daa_res;
        upd.c = 1'b1;
        raw.c = daa_c;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL: begin
        res_o = log_res;
        upd.z = 1'b1;
      end
      OP_RL, OP_RR: res_o = rot_res;
      OP_RLC, OP_RRC: begin
        res_o = rot_res;
        upd.c = 1'b1;
        raw.c = rot_c;
      end
      default: ;
    endcase
    raw.z = (res_o == '0);
  end

  assign c_o      = raw.c  & upd.c;
  assign ac_o     = raw.ac & upd.ac;
  assign z_o      = raw.z  & upd.z;
  assign ov_o     = raw.ov & upd.ov;
  assign upd_c_o  = upd.c;
  assign upd_ac_o = upd.ac;
  assign upd_z_o  = upd.z;
  assign upd_ov_o = upd.ov;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
(
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic [3:0] op_i,
  input logic       c_i,
  input logic [7:0] res_o,
  input logic       c_o,
  input logic       ac_o,
  input logic       z_o,
  input logic       ov_o,
  input logic       upd_c_o,
  input logic       upd_ac_o,
  input logic       upd_z_o,
  input logic       upd_ov_o
);
  always_comb begin
    if (op_i == OP_ADD)
      AST_ADD_SUM: assert ({c_o, res_o} == {1'b0, a_i} + {1'b0, b_i}) else $error("add sum"); // R2
    if (op_i == OP_SUB)
      AST_SUB_NO_BORROW: assert (c_o == (a_i >= b_i) && res_o == a_i - b_i) else $error("sub borrow"); // R3
    if (op_i == OP_ADD)
      AST_HALF_CARRY: assert (ac_o == (({1'b0, a_i[3:0]} + {1'b0, b_i[3:0]}) > 5'd15)) else $error("half carry"); // R4
    if (op_i == OP_ADD)
      AST_ADD_OVERFLOW: assert (ov_o == ((a_i[7] == b_i[7]) && (res_o[7] != a_i[7]))) else $error("overflow"); // R5
    if (op_i == OP_AND)
      AST_AND_ZERO: assert (z_o == ((a_i & b_i) == 8'h00)) else $error("and zero"); // R6
    if (op_i == OP_DAA && c_i)
      AST_DAA_KEEP_CARRY: assert (c_o) else $error("daa carry"); // R7
    if (op_i == OP_RLC)
      AST_RLC_CARRY: assert (c_o == a_i[7] && res_o == {a_i[6:0], c_i}) else $error("rlc"); // R9
    if (op_i == OP_INC || op_i == OP_DEC)
      AST_INCDEC_ZONLY: assert (!upd_c_o && !upd_ac_o && upd_z_o && !upd_ov_o) else $error("incdec upd"); // R10
    AST_MASKED_FLAGS: assert ((upd_c_o || !c_o) && (upd_ac_o || !ac_o) && (upd_z_o || !z_o) && (upd_ov_o || !ov_o)) else $error("mask"); // R11
  end
endmodule

bind alu8_core alu8_chk u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .c_i      (c_i),
  .res_o    (res_o),
  .c_o      (c_o),
  .ac_o     (ac_o),
  .z_o      (z_o),
  .ov_o     (ov_o),
  .upd_c_o  (upd_c_o),
  .upd_ac_o (upd_ac_o),
  .upd_z_o  (upd_z_o),
  .upd_ov_o (upd_ov_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 33;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] a_i, b_i, res_o;
  logic [3:0] op_i;
  logic c_i, ac_i, c_o, ac_o, z_o, ov_o;
  logic upd_c_o, upd_ac_o, upd_z_o, upd_ov_o;

  alu8_core dut (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .c_i(c_i), .ac_i(ac_i),
    .res_o(res_o), .c_o(c_o), .ac_o(ac_o), .z_o(z_o), .ov_o(ov_o),
    .upd_c_o(upd_c_o), .upd_ac_o(upd_ac_o), .upd_z_o(upd_z_o), .upd_ov_o(upd_ov_o)
  );

  // {op, a, b, c, ac, res, flags{c,ac,z,ov}, upd{c,ac,z,ov}}
  localparam logic [37:0] VEC [NVEC] = '{
    {4'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 4'b0101, 4'b1111},
    {4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b1110, 4'b1111},
    {4'd1,  8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 4'b0000, 4'b1111},
    {4'd0,  8'hFF, 8'h01, 1'b1, 1'b0, 8'h00, 4'b1110, 4'b1111},
    {4'd2,  8'h05, 8'h03, 1'b0, 1'b0, 8'h02, 4'b1100, 4'b1111},
    {4'd2,  8'h03, 8'h05, 1'b0, 1'b0, 8'hFE, 4'b0000, 4'b1111},
    {4'd2,  8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 4'b1001, 4'b1111},
    {4'd2,  8'h42, 8'h42, 1'b0, 1'b0, 8'h00, 4'b1110, 4'b1111},
    {4'd3,  8'h05, 8'h03, 1'b0, 1'b0, 8'h01, 4'b1100, 4'b1111},
    {4'd3,  8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b1111},
    {4'd3,  8'h05, 8'h03, 1'b1, 1'b0, 8'h02, 4'b1100, 4'b1111},
    {4'd4,  8'h3C, 8'h00, 1'b0, 1'b0, 8'h42, 4'b0000, 4'b1000},
    {4'd4,  8'hA5, 8'h00, 1'b0, 1'b0, 8'h05, 4'b1000, 4'b1000},
    {4'd4,  8'h99, 8'h00, 1'b1, 1'b1, 8'hFF, 4'b1000, 4'b1000},
    {4'd4,  8'h12, 8'h00, 1'b1, 1'b0, 8'h72, 4'b1000, 4'b1000},
    {4'd5,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 4'b0000, 4'b0010},
    {4'd5,  8'h0F, 8'hF0, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010},
    {4'd6,  8'h12, 8'h21, 1'b0, 1'b0, 8'h33, 4'b0000, 4'b0010},
    {4'd6,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010},
    {4'd7,  8'h5A, 8'hFF, 1'b0, 1'b0, 8'hA5, 4'b0000, 4'b0010},
    {4'd7,  8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010},
    {4'd8,  8'h55, 8'h0F, 1'b0, 1'b0, 8'hAA, 4'b0000, 4'b0010},
    {4'd8,  8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010},
    {4'd9,  8'h81, 8'h00, 1'b1, 1'b0, 8'h03, 4'b0000, 4'b0000},
    {4'd10, 8'h81, 8'h00, 1'b0, 1'b0, 8'hC0, 4'b0000, 4'b0000},
    {4'd11, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 4'b1000, 4'b1000},
    {4'd12, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 4'b1000, 4'b1000},
    {4'd12, 8'h02, 8'h00, 1'b1, 1'b0, 8'h81, 4'b0000, 4'b1000},
    {4'd13, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010},
    {4'd13, 8'h7F, 8'h00, 1'b1, 1'b1, 8'h80, 4'b0000, 4'b0010},
    {4'd14, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0010, 4'b0010},
    {4'd14, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b0010},
    {4'd15, 8'h3C, 8'h77, 1'b1, 1'b1, 8'h3C, 4'b0000, 4'b0000}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1:           return "R2";
      4'd2, 4'd3:           return "R3";
      4'd4:                 return "R7";
      4'd5, 4'd6, 4'd7, 4'd8: return "R8";
      4'd9, 4'd10, 4'd11, 4'd12: return "R9";
      4'd13, 4'd14:         return "R10";
      default:              return "R1";
    endcase
  endfunction

  task automatic drive(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c, logic ac);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; c_i = c; ac_i = ac;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(string req, logic [7:0] er, logic [3:0] ef, logic [3:0] eu);
    logic [3:0] af, au;
    af = {c_o, ac_o, z_o, ov_o};
    au = {upd_c_o, upd_ac_o, upd_z_o, upd_ov_o};
    n_chk++;
    if (res_o !== er || af !== ef || au !== eu) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h: res=%h flags=%b upd=%b, expected res=%h flags=%b upd=%b",
               req, op_i, a_i, b_i, res_o, af, au, er, ef, eu);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    op_i = 4'd0; a_i = '0; b_i = '0; c_i = 1'b0; ac_i = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // quiescent inputs: ADD 0+0 -> 0 with zero set (R6)
    drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R6", 8'h00, 4'b0010, 4'b1111);

    // vector table: R1..R11 (flags/enables compared as R4 R5 R6 R11 too)
    for (int v = 0; v < NVEC; v++) begin
      logic [37:0] w;
      w = VEC[v];
      drive(w[37:34], w[33:26], w[25:18], w[17], w[16]);
      check(req_of(w[37:34]), w[15:8], w[7:4], w[3:0]);
    end

    // R4 R5: add sweep, all flags from integer arithmetic
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 17) begin
        logic [7:0] av, bv, ev;
        logic [8:0] s;
        logic ec, eac, ez, eov;
        av = 8'(i); bv = 8'(j);
        s  = {1'b0, av} + {1'b0, bv};
        ev = s[7:0]; ec = s[8];
        eac = ({1'b0, av[3:0]} + {1'b0, bv[3:0]}) > 5'd15;
        ez = (ev == 8'h00);
        eov = (av[7] == bv[7]) && (ev[7] != av[7]);
        drive(4'd0, av, bv, 1'b0, 1'b0);
        check("R4/R5 add", ev, {ec, eac, ez, eov}, 4'b1111);
      end
    end

    // R3 R4 R5: subtract sweep, inverted borrow
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 17) begin
        logic [7:0] av, bv, ev;
        logic ec, eac, ez, eov;
        av = 8'(i); bv = 8'(j);
        ev = av - bv;
        ec = (av >= bv);
        eac = (av[3:0] >= bv[3:0]);
        ez = (ev == 8'h00);
        eov = (av[7] != bv[7]) && (ev[7] != av[7]);
        drive(4'd2, av, bv, 1'b0, 1'b0);
        check("R3 sub", ev, {ec, eac, ez, eov}, 4'b1111);
      end
    end

    // R8: CPL ignores b_i and carry-in
    drive(4'd8, 8'h3C, 8'hA5, 1'b1, 1'b1);
    check("R8", 8'hC3, 4'b0000, 4'b0000 | 4'b0010);

    // R7: DAA both nibbles over 9 with no incoming flags
    drive(4'd4, 8'hAB, 8'h00, 1'b0, 1'b0);
    check("R7", 8'h11, 4'b1000, 4'b1000);

    finish_run();
  end
endmodule